// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous RAM

This block is a synthesizable model of a small synchronous static RAM with a registered input stage and a registered output stage. On each rising clock edge it captures the chip enable, the write controls, the address and the write data. An upstream burst generator supplies the address. On the following edge the block reads the array, performs any write, and loads the read word into the output register.

The data word is split into byte lanes of nine bits each. A lane is written only when the byte-write qualifier and that lane's select are both high. A separate global-write control writes every lane whatever the byte controls say. Every enabled access returns the word's contents from before that cycle's write, so a write cycle also hands back the value it replaced. A deselected cycle leaves the array untouched. It also clears the output-valid flag one edge later, and that flag is the block's output-enable indication.

Top module: `pipe_lane_sram`

## Requirements
- R1: While reset is asserted, and after its release until an access completes, `rd_valid` is 0 and `rd_data` is 0.
- R2: An access with `en`=1 sampled at rising edge k drives `rd_valid`=1 and its read word on `rd_data` after edge k+1, and not earlier.
- R3: With `en`=1, `gw`=0 and `bwe`=1, lane i (bits `wdata[9*i+8:9*i]`, select `lane_sel[i]`) is written if and only if `lane_sel[i]`=1. Lanes not selected keep their contents.
- R4: With `en`=1 and `gw`=1, all four lanes are written, whatever `bwe` and `lane_sel` are.
- R5: With `en`=1, `gw`=0 and `bwe`=0, no lane is written even if `lane_sel` is all ones. The cycle acts as a plain read.
- R6: An enabled access that writes an address returns that address's contents from before the write on `rd_data`.
- R7: An edge that samples `en`=0 clears `rd_valid` after the next edge and leaves `rd_data` unchanged.
- R8: A deselected cycle does not modify the array, even with `gw`, `bwe` and `lane_sel` all asserted.
- R9: A read captured on the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Chip enable; 0 deselects the cycle |
| gw | input | 1 | Global write, all lanes |
| bwe | input | 1 | Byte-write qualifier for `lane_sel` |
| lane_sel | input | 4 | Per-lane write selects, bit i for lane i |
| addr | input | 8 | Word address from the burst generator |
| wdata | input | 36 | Write data, lane i in bits 9*i+8:9*i |
| rd_data | output | 36 | Registered read word |
| rd_valid | output | 1 | Read word valid / output enable |

## Verification
The assertions take the controls as already qualified: a write is recognised only by `gw`, or by `bwe` together with `lane_sel`. The latency check assumes that reset stays released for the two edges after an enabled cycle is sampled. The bench drives every input on the falling edge, so each value is stable across the capturing edge. It never pulses reset in the middle of a scenario. Before it checks any read, it fills every address it reads with global writes, so no expected value depends on uninitialised array contents.

// File: rtl/pipe_lane_sram_pkg.sv
package pipe_lane_sram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/sram_in_reg.sv
module sram_in_reg #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    gw,
  input  logic                    bwe,
  input  logic [LANES-1:0]        lane_sel,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic                    cap_en,
  output logic                    cap_gw,
  output logic                    cap_bwe,
  output logic [LANES-1:0]        cap_sel,
  output logic [AW-1:0]           cap_addr,
  output logic [LANES*LANE_W-1:0] cap_wdata
);

  // Control is reset so that no spurious access follows reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en  <= 1'b0;
      cap_gw  <= 1'b0;
      cap_bwe <= 1'b0;
      cap_sel <= '0;
    end else begin
      cap_en  <= en;
      cap_gw  <= gw;
      cap_bwe <= bwe;
      cap_sel <= lane_sel;
    end
  end

  // Address and data are not reset; they matter only when cap_en is high.
  always_ff @(posedge clk) begin
    cap_addr  <= addr;
    cap_wdata <= wdata;
  end

endmodule

// File: rtl/sram_we_decode.sv
module sram_we_decode
  import pipe_lane_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cap_en,
  input  logic             cap_gw,
  input  logic             cap_bwe,
  input  logic [LANES-1:0] cap_sel,
  output logic [LANES-1:0] lane_we,
  output acc_kind_e        acc_kind
);

  // Global write wins; otherwise the qualifier gates the per-lane selects.
  function automatic logic [LANES-1:0] lane_mask(input logic g, input logic b,
                                                 input logic [LANES-1:0] s);
    if (g) return '1;
    if (b) return s;
    return '0;
  endfunction

  logic [LANES-1:0] mask;

  always_comb begin
    mask = lane_mask(cap_gw, cap_bwe, cap_sel);
    if (!cap_en) begin
      lane_we  = '0;
      acc_kind = ACC_IDLE;
    end else begin
      lane_we  = mask;
      acc_kind = (|mask) ? ACC_WRITE : ACC_READ;
    end
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 256,
  parameter int AW     = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [AW-1:0]           cap_addr,
  input  logic [LANES*LANE_W-1:0] cap_wdata,
  output logic [LANES*LANE_W-1:0] raw_rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    // Non-blocking write: the combinational read below sees the old word
    // for the whole cycle in which the write is pending.
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[cap_addr] <= cap_wdata[g*LANE_W +: LANE_W];
    end

    assign raw_rdata[g*LANE_W +: LANE_W] = mem[cap_addr];
  end

endmodule

// File: rtl/sram_out_reg.sv
module sram_out_reg
  import pipe_lane_sram_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  acc_kind_e    acc_kind,
  input  logic [W-1:0] raw_rdata,
  output logic [W-1:0] rd_data,
  output logic         rd_valid
);

  logic access;
  assign access = (acc_kind != ACC_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= access;
      if (access) rd_data <= raw_rdata;
    end
  end

  AST_DESEL_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> !rd_valid); // R7
  AST_DESEL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> $stable(rd_data)); // R7

endmodule

// File: rtl/pipe_lane_sram.sv
module pipe_lane_sram
  import pipe_lane_sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gw,
  input  logic             bwe,
  input  logic [LANES-1:0] lane_sel,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rd_data,
  output logic             rd_valid
);

  logic             cap_en, cap_gw, cap_bwe;
  logic [LANES-1:0] cap_sel;
  logic [AW-1:0]    cap_addr;
  logic [W-1:0]     cap_wdata;
  logic [LANES-1:0] lane_we;
  acc_kind_e        acc_kind;
  logic [W-1:0]     raw_rdata;

  sram_in_reg #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) i_in (
    .clk(clk), .rst_n(rst_n), .en(en), .gw(gw), .bwe(bwe),
    .lane_sel(lane_sel), .addr(addr), .wdata(wdata),
    .cap_en(cap_en), .cap_gw(cap_gw), .cap_bwe(cap_bwe), .cap_sel(cap_sel),
    .cap_addr(cap_addr), .cap_wdata(cap_wdata)
  );

  sram_we_decode #(.LANES(LANES)) i_dec (
    .cap_en(cap_en), .cap_gw(cap_gw), .cap_bwe(cap_bwe), .cap_sel(cap_sel),
    .lane_we(lane_we), .acc_kind(acc_kind)
  );

  sram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH), .AW(AW)) i_arr (
    .clk(clk), .lane_we(lane_we), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
    .raw_rdata(raw_rdata)
  );

  sram_out_reg #(.W(W)) i_out (
    .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .raw_rdata(raw_rdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ##2 rd_valid); // R2
  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cap_gw) |-> (&lane_we)); // R4
  AST_BYTE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !cap_gw && !cap_bwe) |-> (lane_we == '0)); // R5
  AST_LANE_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !cap_gw && cap_bwe) |-> (lane_we == cap_sel)); // R3
  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> (lane_we == '0)); // R8
  AST_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_WRITE) |-> cap_en); // R8

endmodule

// File: tb/test_pipe_lane_sram.sv
`timescale 1ns/1ps
module test_pipe_lane_sram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, gw = 1'b0, bwe = 1'b0;
  logic [3:0]  lane_sel = '0;
  logic [7:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rd_data;
  logic        rd_valid;

  int n_chk = 0;
  int n_fail = 0;
  logic [35:0] model [256];

  always #4 clk = ~clk;

  pipe_lane_sram i_pipe_lane_sram (
    .clk(clk), .rst_n(rst_n), .en(en), .gw(gw), .bwe(bwe), .lane_sel(lane_sel),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs after a falling edge; return at the next falling edge.
  task automatic drive(input logic e, input logic g, input logic b, input logic [3:0] s,
                       input logic [7:0] a, input logic [35:0] d);
    en = e; gw = g; bwe = b; lane_sel = s; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 36'h0);
  endtask

  // Expected array update from the lane rules.
  task automatic model_write(input logic g, input logic b, input logic [3:0] s,
                             input logic [7:0] a, input logic [35:0] d);
    for (int i = 0; i < 4; i++)
      if (g || (b && s[i])) model[a][i*9 +: 9] = d[i*9 +: 9];
  endtask

  // Write cycle followed by idle; the returned word must be the old contents.
  task automatic wr(input string req, input logic g, input logic b, input logic [3:0] s,
                    input logic [7:0] a, input logic [35:0] d);
    logic [35:0] old;
    old = model[a];
    drive(1'b1, g, b, s, a, d);
    model_write(g, b, s, a, d);
    idle();
    chk({req, "/R6 old word"}, rd_data, old);
    chk({req, " valid"}, {35'd0, rd_valid}, 36'd1);
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    drive(1'b1, 1'b0, 1'b0, 4'h0, a, 36'h0);
    idle();
    chk({req, " read data"}, rd_data, model[a]);
    chk({req, " read valid"}, {35'd0, rd_valid}, 36'd1);
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", {35'd0, rd_valid}, 36'd0);
    chk("R1 data in reset", rd_data, 36'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(); idle();
    chk("R1 valid after release", {35'd0, rd_valid}, 36'd0);
    chk("R1 data after release", rd_data, 36'd0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 8; a++) begin
      model[a] = 36'h0;
      drive(1'b1, 1'b1, 1'b0, 4'h0, 8'(a), 36'h0);
    end
    idle();
    for (int a = 0; a < 8; a++)
      wr("R4 fill", 1'b1, 1'b0, 4'h0, 8'(a), {4'(a), 32'h5A5A_0000 + 32'(a * 'h111)});
    for (int a = 0; a < 8; a++) rd("R4 readback", 8'(a));
  endtask

  task automatic t_latency();
    idle();
    drive(1'b1, 1'b0, 1'b0, 4'h0, 8'd3, 36'h0);
    chk("R2 not valid one edge after capture", {35'd0, rd_valid}, 36'd0);
    idle();
    chk("R2 valid two edges after capture", {35'd0, rd_valid}, 36'd1);
    chk("R2 data two edges after capture", rd_data, model[3]);
  endtask

  task automatic t_gw_override();
    wr("R4 gw with lane0 only", 1'b1, 1'b1, 4'b0001, 8'd4, 36'h9_8765_4321);
    rd("R4 override all lanes", 8'd4);
    wr("R4 gw with bwe low", 1'b1, 1'b0, 4'b0000, 8'd5, 36'hF_0F0F_0F0F);
    rd("R4 gw bwe low", 8'd5);
  endtask

  task automatic t_bytes();
    for (int i = 0; i < 4; i++) begin
      wr("R3 single lane", 1'b0, 1'b1, 4'(1 << i), 8'd6, 36'hA_BCDE_F123 ^ 36'(i * 'h1FF));
      rd("R3 single lane readback", 8'd6);
    end
    wr("R3 two lanes", 1'b0, 1'b1, 4'b0101, 8'd7, 36'h1_2345_6789);
    rd("R3 two lanes readback", 8'd7);
    wr("R3 lanes 3 and 1", 1'b0, 1'b1, 4'b1010, 8'd7, 36'hE_DCBA_9876);
    rd("R3 lanes 3 and 1 readback", 8'd7);
  endtask

  task automatic t_no_qual();
    wr("R5 sel without bwe", 1'b0, 1'b0, 4'b1111, 8'd2, 36'h0_0000_0000);
    rd("R5 contents unchanged", 8'd2);
  endtask

  task automatic t_back_to_back();
    logic [35:0] old;
    old = model[1];
    drive(1'b1, 1'b1, 1'b0, 4'h0, 8'd1, 36'h3_3333_CCCC);
    model_write(1'b1, 1'b0, 4'h0, 8'd1, 36'h3_3333_CCCC);
    drive(1'b1, 1'b0, 1'b0, 4'h0, 8'd1, 36'h0);
    chk("R6 write cycle returns old word", rd_data, old);
    idle();
    chk("R9 next-cycle read sees new word", rd_data, model[1]);
  endtask

  task automatic t_deselect();
    logic [35:0] held;
    held = model[0];
    drive(1'b1, 1'b0, 1'b0, 4'h0, 8'd0, 36'h0);
    drive(1'b0, 1'b1, 1'b1, 4'b1111, 8'd0, 36'hD_EADB_EEF0);
    chk("R7 read result lands", rd_data, held);
    idle();
    chk("R7 valid low after deselect", {35'd0, rd_valid}, 36'd0);
    chk("R7 data held after deselect", rd_data, held);
    rd("R8 deselected write left array unchanged", 8'd0);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_latency();
    t_gw_override();
    t_bytes();
    t_no_qual();
    t_back_to_back();
    t_deselect();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule